// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing FIFO with Programmable Level Flags

This block is a first-in first-out buffer whose write port and read port run on separate clocks. At master reset it latches one of two timing modes. In standard mode the reader asks for each word with a read enable, and two status pins report empty and full. In fall-through mode the oldest word is presented on the output without being requested, and the same two pins report output-ready and input-ready.

Three further status outputs are driven in both modes. One reports more than half full. The other two report nearly empty and nearly full, against offsets supplied by a neighbouring offset block. Each of the two near flags can be latched at master reset to react through the clock-crossing synchroniser (synchronous) or to follow the opposite side's live pointer (asynchronous).

A partial reset empties the buffer in mid-operation. It keeps the latched mode and the flag timing selections, and the offsets stay with their owner. All status outputs and enables are active low. Pointers cross between clocks as Gray code through two flip-flop stages.

Top module: `dual_mode_fifo`

## Requirements
- R1: While mrst_n is low, mode_sel is latched (0 = standard, 1 = fall-through), together with ae_async_sel and af_async_sel. A partial reset (prst_n low) leaves all three latched values unchanged.
- R2: In standard mode rd_stat_n is low while the storage array holds no word, and wr_stat_n is low while it holds DEPTH words.
- R3: In fall-through mode rd_stat_n is low exactly while a valid head word is on dout, and wr_stat_n is low while the storage array holds fewer than DEPTH words.
- R4: In fall-through mode the first word written reaches dout within four rclk edges, with ren_n high throughout. Each later word replaces it only on an rclk edge with ren_n low, and dout is held otherwise.
- R5: In standard mode, an rclk edge with ren_n low and the array not empty places the oldest stored word on dout. Words leave in the order they were written.
- R6: A write attempted while the array is full and a standard-mode read attempted while it is empty are ignored: no word is stored, lost or repeated.
- R7: half_n is low while the write side counts more than DEPTH/2 stored words.
- R8: near_empty_n is low while the count is at most ae_off, and near_full_n is low while the count is at least DEPTH - af_off. The count covers the storage array only; the fall-through output register is not included.
- R9: A near flag in synchronous timing sees an opposite-side pointer change two of its own clock edges later. In asynchronous timing it sees the change straight after the opposite-side edge. Changes made by its own side show at once.
- R10: Master reset and partial reset each empty the buffer and clear dout to 0. The flags then show the empty state of the mode in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, synchronous, active low, held over edges of both clocks |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| mode_sel | input | 1 | Timing mode, sampled during master reset |
| ae_async_sel | input | 1 | Near-empty flag asynchronous timing, sampled during master reset |
| af_async_sel | input | 1 | Near-full flag asynchronous timing, sampled during master reset |
| ae_off | input | AW | Near-empty offset |
| af_off | input | AW | Near-full offset |
| wen_n | input | 1 | Write enable, active low |
| din | input | DW | Write data |
| ren_n | input | 1 | Read enable, active low |
| dout | output | DW | Read data / head word |
| rd_stat_n | output | 1 | Empty flag (standard) or output-ready (fall-through) |
| wr_stat_n | output | 1 | Full flag (standard) or input-ready (fall-through) |
| half_n | output | 1 | More than half full, active low |
| near_empty_n | output | 1 | Nearly empty, active low |
| near_full_n | output | 1 | Nearly full, active low |

## Verification
A wrong pointer shows up first as a wrong word on dout, or as a status pin with the wrong level. A wrong write pointer shows at once through wr_stat_n and half_n, and reaches the read side two rclk edges later. A wrong latched mode inverts the meaning of both status pins straight after reset, before any data moves. A wrong synchroniser depth or a wrong flag timing selection moves a near flag's edge by a whole number of cycles, and the bench samples at those exact cycles.

// File: rtl/dmf_pkg.sv
// Shared types for the dual-mode FIFO.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dmf_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } mode_e;
endpackage

// File: rtl/dmf_sync2.sv
// Two-stage synchroniser for a Gray-coded pointer.
// Assumes the input changes at most one bit per source clock edge.
module dmf_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift the value through two flops; synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dmf_gray2bin.sv
// Gray to binary converter, purely combinational.
// Assumes W >= 1.
module dmf_gray2bin #(
    parameter int W = 5
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    // Each binary bit is the parity of the Gray bits at and above it.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/dmf_mem.sv
// Storage array: one clocked write port, one combinational read port.
// Assumes the write and read addresses are kept apart by the pointer logic.
module dmf_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Store the incoming word on an accepted write.
    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/dmf_wside.sv
// Write-domain control: write pointer, mode latch, full/input-ready,
// half-full and near-full flags.
// Assumes AW >= 2. rgray_s is the read pointer synchronised into wclk.
// rptr_raw is the live read pointer, used only for asynchronous near-full.
module dmf_wside #(
    parameter int AW = 4,
    localparam int PW = AW + 1
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          mrst_n,
    input  logic          mode_sel,
    input  logic          af_async_sel,
    input  logic          wen_n,
    input  logic [AW-1:0] af_off,
    input  logic [PW-1:0] rgray_s,
    input  logic [PW-1:0] rptr_raw,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] wgray,
    output logic          push,
    output logic          wr_stat_n,
    output logic          half_n,
    output logic          near_full_n
);
    import dmf_pkg::*;

    localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};
    localparam logic [PW-1:0] HALF_CNT = {2'b01, {(AW-1){1'b0}}};

    mode_e         mode_q;
    logic          af_async_q;
    logic [PW-1:0] rbin_s;
    logic [PW-1:0] wcount;
    logic [PW-1:0] nf_count;
    logic [PW:0]   nf_sum;
    logic          full;

    dmf_gray2bin #(.W(PW)) u_rg2b (.gray(rgray_s), .bin(rbin_s));

    assign wcount = wptr - rbin_s;
    assign full   = (wcount == FULL_CNT);
    assign push   = !wen_n && !full;

    // Latch the timing mode and near-full timing during master reset only.
    always_ff @(posedge wclk) begin
        if (!mrst_n) begin
            mode_q     <= mode_sel ? MODE_FWFT : MODE_STD;
            af_async_q <= af_async_sel;
        end
    end

    // Advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (push) begin
            wptr  <= wptr + 1'b1;
            wgray <= (wptr + 1'b1) ^ ((wptr + 1'b1) >> 1);
        end
    end

    // Derive the write-side flags from the count in effect.
    always_comb begin
        nf_count    = af_async_q ? (wptr - rptr_raw) : wcount;
        nf_sum      = {1'b0, nf_count} + {2'b00, af_off};
        near_full_n = !(nf_sum >= {1'b0, FULL_CNT});
        half_n      = !(wcount > HALF_CNT);
        wr_stat_n   = (mode_q == MODE_FWFT) ? full : !full;
    end

    p_no_overflow_r6: assert property (@(posedge wclk) disable iff (!rst_n)
        (full && !wen_n) |=> $stable(wptr));

    p_count_bound_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        wcount <= FULL_CNT);

    p_gray_step_r9: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

    p_mode_kept_r1: assert property (@(posedge wclk) disable iff (!mrst_n)
        1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/dmf_rside.sv
// Read-domain control: read pointer, output register, empty/output-ready
// and near-empty flags.
// Assumes wgray_s is the write pointer synchronised into rclk. wptr_raw is
// the live write pointer, used only for asynchronous near-empty.
module dmf_rside #(
    parameter int DW = 8,
    parameter int AW = 4,
    localparam int PW = AW + 1
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          mrst_n,
    input  logic          mode_sel,
    input  logic          ae_async_sel,
    input  logic          ren_n,
    input  logic [AW-1:0] ae_off,
    input  logic [PW-1:0] wgray_s,
    input  logic [PW-1:0] wptr_raw,
    input  logic [DW-1:0] rdata,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] rgray,
    output logic [DW-1:0] dout,
    output logic          rd_stat_n,
    output logic          near_empty_n
);
    import dmf_pkg::*;

    mode_e         mode_q;
    logic          ae_async_q;
    logic          head_valid;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rcount;
    logic [PW-1:0] ne_count;
    logic          empty;
    logic          pop;

    dmf_gray2bin #(.W(PW)) u_wg2b (.gray(wgray_s), .bin(wbin_s));

    assign rcount = wbin_s - rptr;
    assign empty  = (rcount == '0);

    // Decide when a word leaves the array: on request, or to refill the head.
    always_comb begin
        if (mode_q == MODE_FWFT) pop = !empty && (!head_valid || !ren_n);
        else                     pop = !empty && !ren_n;
    end

    // Latch the timing mode and near-empty timing during master reset only.
    always_ff @(posedge rclk) begin
        if (!mrst_n) begin
            mode_q     <= mode_sel ? MODE_FWFT : MODE_STD;
            ae_async_q <= ae_async_sel;
        end
    end

    // Move the read pointers and the output word; track the head register.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rptr       <= '0;
            rgray      <= '0;
            dout       <= '0;
            head_valid <= 1'b0;
        end else begin
            if (pop) begin
                rptr  <= rptr + 1'b1;
                rgray <= (rptr + 1'b1) ^ ((rptr + 1'b1) >> 1);
                dout  <= rdata;
            end
            if (mode_q == MODE_FWFT) begin
                if (pop)         head_valid <= 1'b1;
                else if (!ren_n) head_valid <= 1'b0;
            end
        end
    end

    // Derive the read-side flags from the count in effect.
    always_comb begin
        ne_count     = ae_async_q ? (wptr_raw - rptr) : rcount;
        near_empty_n = !(ne_count <= {1'b0, ae_off});
        rd_stat_n    = (mode_q == MODE_FWFT) ? !head_valid : !empty;
    end

    p_no_underflow_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (empty && !ren_n && mode_q == MODE_STD) |=> $stable(rptr));

    p_head_held_r4: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode_q == MODE_FWFT && head_valid && ren_n) |=> (head_valid && $stable(dout)));

    p_std_hold_r5: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode_q == MODE_STD && ren_n) |=> $stable(dout));

    p_rmode_kept_r1: assert property (@(posedge rclk) disable iff (!mrst_n)
        1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/dual_mode_fifo.sv
// Dual-clock FIFO with a timing mode latched at master reset and
// programmable level flags.
// Assumes mrst_n and prst_n are held low across at least two edges of
// each clock, and that DEPTH = 2**AW with AW >= 2.
module dual_mode_fifo #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          ae_async_sel,
    input  logic          af_async_sel,
    input  logic [AW-1:0] ae_off,
    input  logic [AW-1:0] af_off,
    input  logic          wen_n,
    input  logic [DW-1:0] din,
    input  logic          ren_n,
    output logic [DW-1:0] dout,
    output logic          rd_stat_n,
    output logic          wr_stat_n,
    output logic          half_n,
    output logic          near_empty_n,
    output logic          near_full_n
);
    localparam int PW = AW + 1;

    logic          dom_rst_n;
    logic [PW-1:0] wptr, wgray, wgray_s;
    logic [PW-1:0] rptr, rgray, rgray_s;
    logic          push;
    logic [DW-1:0] rdata;

    assign dom_rst_n = mrst_n & prst_n;

    dmf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(dom_rst_n), .d(wgray), .q(wgray_s));
    dmf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(dom_rst_n), .d(rgray), .q(rgray_s));

    dmf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wclk), .we(push), .waddr(wptr[AW-1:0]), .wdata(din),
        .raddr(rptr[AW-1:0]), .rdata(rdata)
    );

    dmf_wside #(.AW(AW)) u_wside (
        .wclk(wclk), .rst_n(dom_rst_n), .mrst_n(mrst_n), .mode_sel(mode_sel),
        .af_async_sel(af_async_sel), .wen_n(wen_n), .af_off(af_off),
        .rgray_s(rgray_s), .rptr_raw(rptr), .wptr(wptr), .wgray(wgray),
        .push(push), .wr_stat_n(wr_stat_n), .half_n(half_n),
        .near_full_n(near_full_n)
    );

    dmf_rside #(.DW(DW), .AW(AW)) u_rside (
        .rclk(rclk), .rst_n(dom_rst_n), .mrst_n(mrst_n), .mode_sel(mode_sel),
        .ae_async_sel(ae_async_sel), .ren_n(ren_n), .ae_off(ae_off),
        .wgray_s(wgray_s), .wptr_raw(wptr), .rdata(rdata), .rptr(rptr),
        .rgray(rgray), .dout(dout), .rd_stat_n(rd_stat_n),
        .near_empty_n(near_empty_n)
    );
endmodule

// File: tb/tb_dual_mode_fifo.sv
`timescale 1ns/1ps
module tb_dual_mode_fifo;
    logic       clk = 1'b0;
    logic       mrst_n = 1'b0, prst_n = 1'b1;
    logic       mode_sel = 1'b0, ae_async_sel = 1'b0, af_async_sel = 1'b0;
    logic [3:0] ae_off = 4'd2, af_off = 4'd3;
    logic       wen_n = 1'b1, ren_n = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       rd_stat_n, wr_stat_n, half_n, near_empty_n, near_full_n;
    int         compared = 0, mismatched = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    dual_mode_fifo #(.DW(8), .AW(4)) dut (
        .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_sel(mode_sel), .ae_async_sel(ae_async_sel), .af_async_sel(af_async_sel),
        .ae_off(ae_off), .af_off(af_off), .wen_n(wen_n), .din(din), .ren_n(ren_n),
        .dout(dout), .rd_stat_n(rd_stat_n), .wr_stat_n(wr_stat_n), .half_n(half_n),
        .near_empty_n(near_empty_n), .near_full_n(near_full_n)
    );

    task automatic tick(input int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic mreset(input logic m, input logic aa, input logic fa);
        mrst_n = 1'b0; mode_sel = m; ae_async_sel = aa; af_async_sel = fa;
        tick(3);
        mrst_n = 1'b1; mode_sel = 1'b0; ae_async_sel = 1'b0; af_async_sel = 1'b0;
        tick(1);
    endtask

    task automatic push(input logic [7:0] v);
        wen_n = 1'b0; din = v; tick(1); wen_n = 1'b1;
    endtask

    task automatic pop(input string tag, input logic [7:0] exp);
        ren_n = 1'b0; tick(1); ren_n = 1'b1;
        chk(tag, dout, exp);
    endtask

    task automatic t_reset_state();
        mreset(1'b0, 1'b0, 1'b0);
        chk("R10 reset rd_stat_n empty", rd_stat_n, 1'b0);
        chk("R2 reset wr_stat_n not full", wr_stat_n, 1'b1);
        chk("R7 reset half_n", half_n, 1'b1);
        chk("R8 reset near_empty_n", near_empty_n, 1'b0);
        chk("R8 reset near_full_n", near_full_n, 1'b1);
        chk("R10 reset dout", dout, 8'h00);
    endtask

    task automatic t_std_order();
        push(8'hA1); push(8'hB2); push(8'hC3);
        tick(3);
        chk("R2 not empty after writes", rd_stat_n, 1'b1);
        chk("R8 near_empty_n count 3 > 2", near_empty_n, 1'b1);
        pop("R5 first word", 8'hA1);
        pop("R5 second word", 8'hB2);
        tick(2);
        chk("R5 dout held without ren", dout, 8'hB2);
        pop("R5 third word", 8'hC3);
        chk("R2 empty after last read", rd_stat_n, 1'b0);
        chk("R8 near_empty_n count 0", near_empty_n, 1'b0);
    endtask

    task automatic t_std_full();
        mreset(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 8; i++) push(8'h10 + 8'(i));
        chk("R7 half_n at count 8", half_n, 1'b1);
        push(8'h18);
        chk("R7 half_n at count 9", half_n, 1'b0);
        for (int i = 9; i < 12; i++) push(8'h10 + 8'(i));
        chk("R8 near_full_n at count 12", near_full_n, 1'b1);
        push(8'h1C);
        chk("R8 near_full_n at count 13", near_full_n, 1'b0);
        for (int i = 13; i < 16; i++) push(8'h10 + 8'(i));
        chk("R2 full flag at 16", wr_stat_n, 1'b0);
        push(8'hEE);
        tick(3);
        chk("R6 still full after extra write", wr_stat_n, 1'b0);
        for (int i = 0; i < 16; i++) pop("R6 R5 drain order", 8'h10 + 8'(i));
        chk("R2 empty after drain", rd_stat_n, 1'b0);
        pop("R6 read while empty keeps dout", 8'h1F);
        push(8'h77);
        tick(3);
        pop("R6 pointer not moved by empty read", 8'h77);
    endtask

    task automatic t_almost_empty();
        mreset(1'b0, 1'b0, 1'b0);
        push(8'h01); push(8'h02);
        tick(3);
        chk("R8 near_empty_n at count 2", near_empty_n, 1'b0);
        push(8'h03);
        tick(3);
        chk("R8 near_empty_n at count 3", near_empty_n, 1'b1);
    endtask

    task automatic t_fwft();
        mreset(1'b1, 1'b0, 1'b0);
        chk("R1 R3 fwft reset not ready", rd_stat_n, 1'b1);
        chk("R3 fwft input ready", wr_stat_n, 1'b0);
        push(8'h5A);
        tick(4);
        chk("R3 output ready", rd_stat_n, 1'b0);
        chk("R4 first word falls through", dout, 8'h5A);
        push(8'h6B);
        tick(4);
        chk("R4 head held without ren", dout, 8'h5A);
        pop("R4 advance on ren", 8'h6B);
        chk("R3 still ready", rd_stat_n, 1'b0);
        ren_n = 1'b0; tick(1); ren_n = 1'b1;
        chk("R3 not ready after last taken", rd_stat_n, 1'b1);
        for (int i = 0; i < 17; i++) push(8'h80 + 8'(i));
        chk("R3 input not ready when array full", wr_stat_n, 1'b1);
        tick(4);
        chk("R4 head is oldest", dout, 8'h80);
        push(8'hFF);
        for (int i = 1; i < 17; i++) pop("R4 R6 fwft drain", 8'h80 + 8'(i));
        ren_n = 1'b0; tick(1); ren_n = 1'b1;
        chk("R6 no extra word in fwft", rd_stat_n, 1'b1);
        chk("R6 dout kept", dout, 8'h90);
    endtask

    task automatic t_partial();
        push(8'h11); push(8'h22);
        tick(4);
        prst_n = 1'b0; mode_sel = 1'b0; tick(2); prst_n = 1'b1; tick(1);
        chk("R10 partial reset clears dout", dout, 8'h00);
        chk("R1 mode kept: not ready", rd_stat_n, 1'b1);
        chk("R1 mode kept: input ready", wr_stat_n, 1'b0);
        push(8'h3C);
        tick(4);
        chk("R1 R4 still falls through", dout, 8'h3C);
    endtask

    task automatic t_timing();
        ae_off = 4'd0; af_off = 4'd0;
        mreset(1'b0, 1'b1, 1'b1);
        push(8'h01);
        chk("R9 async near_empty immediate", near_empty_n, 1'b1);
        mreset(1'b0, 1'b0, 1'b0);
        chk("R10 master reset empties", rd_stat_n, 1'b0);
        push(8'h02);
        chk("R9 sync near_empty not yet", near_empty_n, 1'b0);
        tick(2);
        chk("R9 sync near_empty after two edges", near_empty_n, 1'b1);
        mreset(1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 16; i++) push(8'(i));
        chk("R8 near_full_n at 16 offset 0", near_full_n, 1'b0);
        tick(3);
        pop("R9 async read data", 8'h00);
        chk("R9 async near_full immediate", near_full_n, 1'b1);
        mreset(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) push(8'(i));
        tick(3);
        pop("R9 sync read data", 8'h00);
        chk("R9 sync near_full not yet", near_full_n, 1'b0);
        tick(2);
        chk("R9 sync near_full after two edges", near_full_n, 1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        tick(1);
        t_reset_state();
        t_std_order();
        t_std_full();
        t_almost_empty();
        t_fwft();
        t_partial();
        t_timing();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule